// File: doc/BRIEF.md
# Differential Bi-phase Bit Decoder

This block turns a demodulated, differential bi-phase coded data line into a stream of bits. The line is first brought into the clock domain through a short flop chain. The block then measures, in clock cycles, how long the line holds each level. Each such run length is judged against a nominal bit period, given as a parameter in clock cycles. For a 2 kbit/s line this parameter is the clock rate divided by 2000.

In this code a transition always marks the start of a bit, and a 1 carries an extra transition at mid-bit. The decoder therefore reports a 1 when two consecutive runs together span one bit period. It reports a 0 when a single run spans one bit period. A run clearly longer than a bit period means the line has gone idle. The decoder then raises a one-cycle abort strobe so that a downstream byte framer can return to its idle state. One special case covers a half-period run that follows such an idle gap and ends on a falling transition. That run is doubled and accepted as a 1, so the first bit after a gap is not lost. Byte framing and packet assembly happen downstream.

Top module: `biphase_bit_decoder`

## Requirements
- R1: After reset, the first level transition seen on the line only starts timing and produces no output. Reset also discards any stored run. A run left over from before reset never pairs with a run after it.
- R2: A run counts as one bit period only if its length L in cycles meets 0.75·P < L < 1.25·P, where P is the bit-period parameter. For P = 40 this means 31 to 49 cycles inclusive. A run of 30 or 50 cycles is not one bit period.
- R3: When a stored run and the current run together form one bit period, the block emits a 1 and discards the stored run. A third short run after such a 1 produces nothing on its own.
- R4: The block tries pairing with the stored run before it judges the current run alone. A stored 10-cycle run followed by a 35-cycle run yields a single 1, not a 0.
- R5: With no run stored, a run that alone forms one bit period emits a 0 and leaves nothing stored.
- R6: A run of more than 1.25·P cycles (51 or more for P = 40) that does not pair produces an abort strobe and no bit. That run is kept as the stored run.
- R7: On a transition from high to low, the block emits a 1 if twice the current run forms one bit period and the stored run exceeds 1.25·P. It does not do this on a transition from low to high, or when the stored run is exactly 1.25·P.
- R8: The run counter saturates instead of wrapping. A run far longer than the counter range still yields exactly one abort, and it still acts as a long stored run.
- R9: Outputs are registered one-cycle strobes. bit_valid_o and abort_o are never high in the same cycle. bit_value_o is meaningful only while bit_valid_o is high, with 1 meaning a logic 1.
- R10: A run that is neither one bit period nor longer than 1.25·P produces no output. It is kept as the stored run and can pair with the next run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_i | input | 1 | Demodulated data line, asynchronous to clk |
| bit_valid_o | output | 1 | One-cycle strobe marking a decoded bit |
| bit_value_o | output | 1 | Decoded bit value, qualified by bit_valid_o |
| abort_o | output | 1 | One-cycle strobe: an overlong run was seen |

## Verification
The hardest situation to reach from the ports is the idle-gap recovery. It needs a long run to be stored first, then a half-period run that ends on a falling transition, and a rising-edge variant of the same lengths must be shown to stay silent. The bench controls the polarity of every run: after reset it always primes the line low, so runs at even positions end on a rising edge and runs at odd positions end on a falling edge. Each sequence is then placed so that the run under test lands at the wanted parity. Boundary lengths of 30/31, 49/50 and 50/51 cycles cover the strict window edges. A mid-sequence reset shows that stored history is dropped.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Number of flops in the input synchroniser
    localparam int unsigned SYNC_STAGES_DEF = 2;

    // Compute the tolerance window and long-run limit from the bit period.
    // Window: 0.75*P < L < 1.25*P, integer cycles.
    function automatic int unsigned win_lo(input int unsigned p);
        return (3 * p) / 4 + 1;
    endfunction

    function automatic int unsigned win_hi(input int unsigned p);
        return (5 * p + 3) / 4 - 1;
    endfunction

    // First run length strictly above 1.25*P
    function automatic int unsigned long_lo(input int unsigned p);
        return (5 * p) / 4 + 1;
    endfunction

endpackage

// File: rtl/bp_sync.sv
module bp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= sh_d;
    end

    assign sync_o = sh_q[STAGES-1];

    // The first stage follows the raw input one cycle later
    p_first_stage_r1: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> sh_q[0] == $past(async_i));

endmodule

// File: rtl/bp_run_timer.sv
module bp_run_timer #(
    parameter int unsigned CNT_MAX = 80,
    localparam int unsigned CNT_W = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lvl_i,
    output logic             edge_o,
    output logic             fall_o,
    output logic [CNT_W-1:0] run_o
);
    typedef struct packed {
        logic             lvl;
        logic             seen;
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t st_d, st_q;
    logic   is_edge;

    always_comb begin
        st_d    = st_q;
        is_edge = (lvl_i != st_q.lvl);
        st_d.lvl = lvl_i;
        if (is_edge) begin
            st_d.cnt  = CNT_W'(1);
            st_d.seen = 1'b1;
        end else if (st_q.cnt != CNT_W'(CNT_MAX)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.lvl  <= 1'b1;
            st_q.seen <= 1'b0;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // The first transition after reset only starts timing
    assign edge_o = is_edge && st_q.seen;
    assign fall_o = !lvl_i;
    assign run_o  = st_q.cnt;

    // Counter never passes its ceiling
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CNT_W'(CNT_MAX));

    // Once at the ceiling and the level holds, the count stays put
    p_cnt_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == CNT_W'(CNT_MAX) && lvl_i == st_q.lvl) |=> st_q.cnt == CNT_W'(CNT_MAX));

    // A reported transition restarts the count
    p_restart_r1: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> st_q.cnt == CNT_W'(1));

endmodule

// File: rtl/bp_classifier.sv
module bp_classifier
    import bp_pkg::*;
#(
    parameter int unsigned BIT_CYCLES = 40,
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_i,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] run_i,
    output logic             bit_valid_o,
    output logic             bit_value_o,
    output logic             abort_o
);
    localparam int unsigned SUM_W   = CNT_W + 1;
    localparam int unsigned WIN_MIN = win_lo(BIT_CYCLES);
    localparam int unsigned WIN_MAX = win_hi(BIT_CYCLES);
    localparam int unsigned LONG_MIN = long_lo(BIT_CYCLES);

    typedef struct packed {
        logic             prev_vld;
        logic [CNT_W-1:0] prev;
        logic             bit_vld;
        logic             bit_val;
        logic             abort;
    } cls_t;

    cls_t st_d, st_q;

    logic [SUM_W-1:0] run_w, sum_w, dbl_w;
    logic             sum_ok, dbl_ok, one_ok, prev_long, pair_ok, run_long;

    function automatic logic in_win(input logic [SUM_W-1:0] v);
        return (v >= SUM_W'(WIN_MIN)) && (v <= SUM_W'(WIN_MAX));
    endfunction

    always_comb begin
        run_w     = SUM_W'(run_i);
        sum_w     = SUM_W'(st_q.prev) + run_w;
        dbl_w     = run_w << 1;
        sum_ok    = in_win(sum_w);
        dbl_ok    = in_win(dbl_w);
        one_ok    = in_win(run_w);
        prev_long = SUM_W'(st_q.prev) >= SUM_W'(LONG_MIN);
        run_long  = run_w >= SUM_W'(LONG_MIN);
        pair_ok   = st_q.prev_vld && (sum_ok || (fall_i && dbl_ok && prev_long));

        st_d         = st_q;
        st_d.bit_vld = 1'b0;
        st_d.abort   = 1'b0;
        if (edge_i) begin
            if (pair_ok) begin
                st_d.bit_vld  = 1'b1;
                st_d.bit_val  = 1'b1;
                st_d.prev_vld = 1'b0;
            end else if (one_ok) begin
                st_d.bit_vld  = 1'b1;
                st_d.bit_val  = 1'b0;
                st_d.prev_vld = 1'b0;
            end else begin
                st_d.prev     = run_i;
                st_d.prev_vld = 1'b1;
                st_d.abort    = run_long;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_valid_o = st_q.bit_vld;
    assign bit_value_o = st_q.bit_val;
    assign abort_o     = st_q.abort;

    // Bit and abort strobes never coincide
    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(bit_valid_o && abort_o));

    // Every strobe follows a measured transition
    p_strobe_src_r9: assert property (@(posedge clk) disable iff (rst)
        (bit_valid_o || abort_o) |-> $past(edge_i));

    // A decoded zero came from a run inside the window
    p_zero_win_r2: assert property (@(posedge clk) disable iff (rst)
        (bit_valid_o && !bit_value_o) |->
            ($past(run_i) >= CNT_W'(WIN_MIN) && $past(run_i) <= CNT_W'(WIN_MAX)));

    // An abort came from a run beyond the long limit
    p_abort_long_r6: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> $past(run_i) >= CNT_W'(LONG_MIN));

endmodule

// File: rtl/biphase_bit_decoder.sv
module biphase_bit_decoder
    import bp_pkg::*;
#(
    parameter int unsigned BIT_CYCLES  = 25000,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic bit_valid_o,
    output logic bit_value_o,
    output logic abort_o
);
    localparam int unsigned CNT_MAX = 2 * BIT_CYCLES;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    logic             line_s;
    logic             run_edge;
    logic             run_fall;
    logic [CNT_W-1:0] run_len;

    bp_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (line_i),
        .sync_o  (line_s)
    );

    bp_run_timer #(
        .CNT_MAX (CNT_MAX)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (line_s),
        .edge_o (run_edge),
        .fall_o (run_fall),
        .run_o  (run_len)
    );

    bp_classifier #(
        .BIT_CYCLES (BIT_CYCLES),
        .CNT_W      (CNT_W)
    ) u_cls (
        .clk         (clk),
        .rst         (rst),
        .edge_i      (run_edge),
        .fall_i      (run_fall),
        .run_i       (run_len),
        .bit_valid_o (bit_valid_o),
        .bit_value_o (bit_value_o),
        .abort_o     (abort_o)
    );

endmodule

// File: tb/sim_biphase_bit_decoder.sv
module sim_biphase_bit_decoder;

    localparam int unsigned P = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line = 1'b1;
    logic bit_valid, bit_value, abort_s;

    int checks = 0;
    int failures = 0;
    int overlap = 0;
    bit done = 1'b0;
    int events[$];

    always #10 clk = ~clk;

    biphase_bit_decoder #(.BIT_CYCLES(P)) u0 (
        .clk         (clk),
        .rst         (rst),
        .line_i      (line),
        .bit_valid_o (bit_valid),
        .bit_value_o (bit_value),
        .abort_o     (abort_s)
    );

    // Event codes: 0 = bit 0, 1 = bit 1, 2 = abort
    always @(negedge clk) begin
        if (!rst) begin
            if (bit_valid) events.push_back(bit_value ? 1 : 0);
            if (abort_s)   events.push_back(2);
            if (bit_valid && abort_s) overlap++;
        end
    end

    function automatic string fmt(input int q[$]);
        string s = "[";
        foreach (q[i]) s = {s, $sformatf("%0d ", q[i])};
        return {s, "]"};
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        line = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        events.delete();
        @(negedge clk);
    endtask

    // Prime low, then hold each run and toggle; even index ends rising, odd falling
    task automatic play(input string tag, input int n, input int runs[8],
                        input int ne, input int ex[4]);
        int want[$];
        bit bad;
        do_reset();
        line = 1'b0;
        for (int i = 0; i < n; i++) begin
            repeat (runs[i]) @(negedge clk);
            line = ~line;
        end
        repeat (8) @(negedge clk);
        for (int i = 0; i < ne; i++) want.push_back(ex[i]);
        bad = (events.size() != want.size());
        if (!bad) foreach (want[i]) if (events[i] != want[i]) bad = 1'b1;
        checks++;
        if (bad) begin
            failures++;
            $display("FAIL %s: actual %s expected %s", tag, fmt(events), fmt(want));
        end
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (bit_valid !== 1'b0 || abort_s !== 1'b0) begin
            failures++;
            $display("FAIL R9 reset: actual %b%b expected 00", bit_valid, abort_s);
        end
    endtask

    // R1: long wait before first edge gives no abort; reset drops stored run
    task automatic t_first_edge();
        do_reset();
        repeat (100) @(negedge clk);
        line = 1'b0;
        repeat (40) @(negedge clk);
        line = 1'b1;
        repeat (8) @(negedge clk);
        checks++;
        if (events.size() != 1 || events[0] != 0) begin
            failures++;
            $display("FAIL R1 first edge: actual %s expected [0 ]", fmt(events));
        end
        do_reset();
        line = 1'b0;
        repeat (25) @(negedge clk);
        line = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        events.delete();
        line = 1'b0;
        repeat (15) @(negedge clk);
        line = 1'b1;
        repeat (8) @(negedge clk);
        checks++;
        if (events.size() != 0) begin
            failures++;
            $display("FAIL R1 history cleared: actual %s expected [ ]", fmt(events));
        end
    endtask

    task automatic t_window();
        play("R2 run 31",  1, '{31,0,0,0,0,0,0,0}, 1, '{0,0,0,0});
        play("R2 run 49",  1, '{49,0,0,0,0,0,0,0}, 1, '{0,0,0,0});
        play("R2 run 30",  1, '{30,0,0,0,0,0,0,0}, 0, '{0,0,0,0});
        play("R10 run 50", 1, '{50,0,0,0,0,0,0,0}, 0, '{0,0,0,0});
        play("R10 kept 25+15", 2, '{25,15,0,0,0,0,0,0}, 1, '{1,0,0,0});
    endtask

    task automatic t_pairs();
        play("R3 pair",       2, '{20,20,0,0,0,0,0,0}, 1, '{1,0,0,0});
        play("R3 cleared",    3, '{20,20,20,0,0,0,0,0}, 1, '{1,0,0,0});
        play("R3 two ones",   4, '{20,20,20,20,0,0,0,0}, 2, '{1,1,0,0});
        play("R4 pair first", 2, '{10,35,0,0,0,0,0,0}, 1, '{1,0,0,0});
        play("R5 zeros",      3, '{40,40,40,0,0,0,0,0}, 3, '{0,0,0,0});
        play("R5 mixed",      4, '{40,20,20,40,0,0,0,0}, 3, '{0,1,0,0});
    endtask

    task automatic t_long();
        play("R6 abort 51",     1, '{51,0,0,0,0,0,0,0}, 1, '{2,0,0,0});
        play("R6 abort then 0", 2, '{60,40,0,0,0,0,0,0}, 2, '{2,0,0,0});
        play("R7 fall recover", 2, '{60,20,0,0,0,0,0,0}, 2, '{2,1,0,0});
        play("R7 rise no",      3, '{40,60,20,0,0,0,0,0}, 2, '{0,2,0,0});
        play("R7 prev 50 no",   2, '{50,20,0,0,0,0,0,0}, 0, '{0,0,0,0});
        play("R8 saturate",     2, '{300,20,0,0,0,0,0,0}, 2, '{2,1,0,0});
    endtask

    initial begin
        t_reset_state();
        t_first_edge();
        t_window();
        t_pairs();
        t_long();
        checks++;
        if (overlap != 0) begin
            failures++;
            $display("FAIL R9 overlap: actual %0d expected 0", overlap);
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule